// File: doc/BRIEF.md
# Wrapping Burst Address Sequencer

This block supplies the internal register address for a multiplexed register bus. Each transaction begins with an address cycle. In that cycle the bus carries a 16-bit address word. Bit 15 of the word picks between two modes:

- **Single access.** The low five bits name one register, and exactly one data cycle follows.
- **Burst.** The low five bits give a first address and bits 9:5 give a last address. The block then walks the address once per data cycle. After it emits the last address it returns to the first one.

The burst lasts as long as the strobe stays high. The cycle in which the strobe is low is the final data cycle. The block sets the direction of the burst (read or write) in the address cycle and does not change it afterwards. A direction change in the middle of a burst raises a one-cycle error pulse and is otherwise ignored. A read burst can be run in hold mode, where each address stays valid for two data cycles. After any read burst, the block ignores the strobe for two cycles to leave room for bus turnaround.

Top module: `burst_addr_seq`

## Requirements
- R1: When bit 15 of the address word is 0, the cycle after the address cycle is the only data cycle. In it `addr_valid`=1, `burst_active`=0 and `reg_addr` equals bits 4:0. Bits 9:5 have no effect in this mode.
- R2: When bit 15 of the address word is 1, the first data cycle follows the address cycle. In it `burst_active`=1, `addr_valid`=1 and `reg_addr` equals bits 4:0, the first address.
- R3: During a burst, the address after `reg_addr` == last address (bits 9:5) is the first address. Every other address is followed by `reg_addr`+1.
- R4: When the last address is below the first address, the address counts up modulo 32 through 31 and 0 until it reaches the last address. It then returns to the first address.
- R5: A data cycle in which `strobe` is 0 is the last cycle of the burst. In the following cycle `addr_valid` and `burst_active` are 0.
- R6: In a read burst (`rd_nwr`=1 in the address cycle) with `hold_ext`=1 in the address cycle, each address is presented for two consecutive data cycles. In a write burst, `hold_ext` has no effect and the address advances every data cycle.
- R7: After a read burst ends, the strobe is ignored for two cycles. The earliest new address cycle is the third cycle after the final data cycle.
- R8: If `rd_nwr` differs from the burst direction in a burst data cycle, `rw_error` is 1 in the next cycle. `burst_read` keeps the direction latched in the address cycle, and the address sequence is unaffected.
- R9: After reset, `addr_valid`, `burst_active` and `rw_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| strobe | input | 1 | Address strobe: starts a transaction when idle, continues a burst when high |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| hold_ext | input | 1 | Read-hold request, sampled in the address cycle |
| addr_word | input | 16 | Captured address word: bit 15 burst, bits 9:5 last, bits 4:0 first/single |
| reg_addr | output | 5 | Current register address |
| addr_valid | output | 1 | High in each data cycle |
| burst_active | output | 1 | High in burst data cycles |
| burst_read | output | 1 | Direction latched for the current transaction |
| rw_error | output | 1 | One-cycle pulse after a direction change inside a burst |

## Verification
The bench builds the block with its default parameters: a 5-bit address field and a 16-bit word. The full 32-entry address ring is therefore reachable, so the bench drives a burst that wraps from 31 through 0 and one that loops over a two-address window in hold mode. With the default gap of two cycles, the bench probes the turnaround window after a read burst with strobe held high, one cycle at a time.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW  = 5,
  parameter int WW  = 16,
  parameter int GAP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          rd_nwr,
  input  logic          hold_ext,
  input  logic [WW-1:0] addr_word,
  output logic [AW-1:0] reg_addr,
  output logic          addr_valid,
  output logic          burst_active,
  output logic          burst_read,
  output logic          rw_error
);
  localparam int BURST_BIT = WW - 1;
  localparam int GW = $clog2(GAP + 1);

  logic          active_q, burst_q, rw_q, hold_q, phase_q, err_q;
  logic [AW-1:0] start_q, stop_q, addr_q;
  logic [GW-1:0] guard_q;

  wire load    = !active_q && strobe && (guard_q == '0);
  wire slow    = rw_q && hold_q;
  wire step_ok = !slow || phase_q;
  wire [AW-1:0] next_addr = (addr_q == stop_q) ? start_q : addr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      burst_q  <= 1'b0;
      rw_q     <= 1'b0;
      hold_q   <= 1'b0;
      phase_q  <= 1'b0;
      err_q    <= 1'b0;
      start_q  <= '0;
      stop_q   <= '0;
      addr_q   <= '0;
      guard_q  <= '0;
    end else begin
      err_q <= 1'b0;
      if (guard_q != '0) guard_q <= guard_q - 1'b1;
      if (load) begin
        active_q <= 1'b1;
        burst_q  <= addr_word[BURST_BIT];
        start_q  <= addr_word[AW-1:0];
        stop_q   <= addr_word[2*AW-1:AW];
        addr_q   <= addr_word[AW-1:0];
        rw_q     <= rd_nwr;
        hold_q   <= hold_ext;
        phase_q  <= 1'b0;
      end else if (active_q) begin
        if (burst_q && (rd_nwr != rw_q)) err_q <= 1'b1;
        if (!burst_q || !strobe) begin
          active_q <= 1'b0;
          if (burst_q && rw_q) guard_q <= GW'(GAP);
        end else begin
          phase_q <= ~phase_q;
          if (step_ok) addr_q <= next_addr;
        end
      end
    end
  end

  assign reg_addr     = addr_q;
  assign addr_valid   = active_q;
  assign burst_active = active_q && burst_q;
  assign burst_read   = rw_q;
  assign rw_error     = err_q;
endmodule

module burst_addr_seq_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe,
  input logic          rd_nwr,
  input logic [AW-1:0] reg_addr,
  input logic          addr_valid,
  input logic          burst_active,
  input logic          burst_read,
  input logic          rw_error,
  input logic          hold_q,
  input logic [AW-1:0] start_q,
  input logic [AW-1:0] stop_q
);
  assert_single_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !burst_active) |=> !addr_valid);

  assert_step_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && strobe && !(burst_read && hold_q)) |=>
      (reg_addr == (($past(reg_addr) == $past(stop_q)) ? $past(start_q) : $past(reg_addr) + 1'b1)));

  assert_strobe_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !strobe) |=> (!addr_valid && !burst_active));

  assert_hold_pairs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && strobe && burst_read && hold_q && $past(burst_active) && !$stable(reg_addr)) |=> $stable(reg_addr));

  assert_read_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !strobe && burst_read) |=> !addr_valid ##1 !addr_valid ##1 !addr_valid);

  assert_dir_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && strobe && (rd_nwr != burst_read)) |=> (rw_error && $stable(burst_read)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .rd_nwr(rd_nwr),
  .reg_addr(reg_addr), .addr_valid(addr_valid), .burst_active(burst_active),
  .burst_read(burst_read), .rw_error(rw_error),
  .hold_q(hold_q), .start_q(start_q), .stop_q(stop_q)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0, rd_nwr = 1'b0, hold_ext = 1'b0;
  logic [15:0] addr_word = '0;
  logic [4:0] reg_addr;
  logic addr_valid, burst_active, burst_read, rw_error;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rd_nwr(rd_nwr), .hold_ext(hold_ext),
    .addr_word(addr_word), .reg_addr(reg_addr), .addr_valid(addr_valid),
    .burst_active(burst_active), .burst_read(burst_read), .rw_error(rw_error)
  );

  // {strobe, rd, hold, word, exp_valid, exp_burst, exp_addr, req}
  localparam int N = 31;
  localparam logic [29:0] VEC [N] = '{
    {3'b100, 16'h80C3, 2'b00, 5'd0,  4'd2}, // R2: write burst 3..6
    {3'b100, 16'h80C3, 2'b11, 5'd3,  4'd2},
    {3'b100, 16'h80C3, 2'b11, 5'd4,  4'd3},
    {3'b100, 16'h80C3, 2'b11, 5'd5,  4'd3},
    {3'b100, 16'h80C3, 2'b11, 5'd6,  4'd3},
    {3'b100, 16'h80C3, 2'b11, 5'd3,  4'd3},
    {3'b000, 16'h80C3, 2'b11, 5'd4,  4'd5},
    {3'b000, 16'h80C3, 2'b00, 5'd0,  4'd5},
    {3'b100, 16'h03E5, 2'b00, 5'd0,  4'd1}, // R1: single, stop field set
    {3'b000, 16'h03E5, 2'b10, 5'd5,  4'd1},
    {3'b000, 16'h03E5, 2'b00, 5'd0,  4'd1},
    {3'b100, 16'h803E, 2'b00, 5'd0,  4'd4}, // R4: 30..1 modulo
    {3'b100, 16'h803E, 2'b11, 5'd30, 4'd4},
    {3'b100, 16'h803E, 2'b11, 5'd31, 4'd4},
    {3'b100, 16'h803E, 2'b11, 5'd0,  4'd4},
    {3'b100, 16'h803E, 2'b11, 5'd1,  4'd4},
    {3'b100, 16'h803E, 2'b11, 5'd30, 4'd4},
    {3'b000, 16'h803E, 2'b11, 5'd31, 4'd5},
    {3'b000, 16'h803E, 2'b00, 5'd0,  4'd5},
    {3'b111, 16'h8128, 2'b00, 5'd0,  4'd6}, // R6: read hold 8..9
    {3'b111, 16'h8128, 2'b11, 5'd8,  4'd6},
    {3'b111, 16'h8128, 2'b11, 5'd8,  4'd6},
    {3'b111, 16'h8128, 2'b11, 5'd9,  4'd6},
    {3'b111, 16'h8128, 2'b11, 5'd9,  4'd6},
    {3'b111, 16'h8128, 2'b11, 5'd8,  4'd6},
    {3'b011, 16'h8128, 2'b11, 5'd8,  4'd5},
    {3'b100, 16'h0007, 2'b00, 5'd0,  4'd7}, // R7: gap ignores strobe
    {3'b100, 16'h0007, 2'b00, 5'd0,  4'd7},
    {3'b100, 16'h0007, 2'b00, 5'd0,  4'd7},
    {3'b000, 16'h0007, 2'b10, 5'd7,  4'd7},
    {3'b000, 16'h0007, 2'b00, 5'd0,  4'd7}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic r, input logic h, input logic [15:0] w);
    @(negedge clk);
    strobe = s; rd_nwr = r; hold_ext = h; addr_word = w;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1;
    check("R9", "addr_valid", addr_valid, 0);
    check("R9", "burst_active", burst_active, 0);
    check("R9", "rw_error", rw_error, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      string rq;
      drive(VEC[i][29], VEC[i][28], VEC[i][27], VEC[i][26:11]);
      rq = $sformatf("R%0d", VEC[i][3:0]);
      check(rq, $sformatf("row %0d valid", i), addr_valid, VEC[i][10]);
      check(rq, $sformatf("row %0d burst", i), burst_active, VEC[i][9]);
      if (VEC[i][10]) check(rq, $sformatf("row %0d addr", i), reg_addr, VEC[i][8:4]);
    end

    // R8 and R6 (write burst ignores hold): burst 2..3, direction flips mid-burst
    drive(1'b1, 1'b0, 1'b1, 16'h8062);
    drive(1'b1, 1'b0, 1'b0, 16'h0);
    check("R6", "write hold addr", reg_addr, 2);
    drive(1'b1, 1'b1, 1'b0, 16'h0);
    check("R6", "write hold step", reg_addr, 3);
    check("R8", "err before", rw_error, 0);
    drive(1'b1, 1'b0, 1'b0, 16'h0);
    check("R8", "rw_error pulse", rw_error, 1);
    check("R8", "burst_read locked", burst_read, 0);
    check("R8", "addr unaffected", reg_addr, 2);
    drive(1'b0, 1'b0, 1'b0, 16'h0);
    check("R8", "err cleared", rw_error, 0);
    check("R3", "wrap step", reg_addr, 3);
    drive(1'b0, 1'b0, 1'b0, 16'h0);
    check("R5", "ended", addr_valid, 0);

    // R9: reset mid-burst returns to idle
    drive(1'b1, 1'b0, 1'b0, 16'h8021);
    drive(1'b1, 1'b0, 1'b0, 16'h0);
    check("R2", "start again", reg_addr, 1);
    rst_n = 1'b0;
    #1;
    check("R9", "reset valid", addr_valid, 0);
    check("R9", "reset burst", burst_active, 0);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule